// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is the execution stage for 64-bit packed-integer operations. Each issued operation brings a destination value, a source value (already fetched from a register or from memory) and the second opcode byte. The block splits the operands into byte, word or doubleword lanes as the opcode asks. It then adds, averages or compares each lane, or combines the full 64 bits bitwise. The 64-bit answer is returned two clocks later, together with a valid strobe.

The lane behaviour depends on the opcode. A word add may clamp at the top of the unsigned range or wrap around. Averages round halves upward. Compares produce masks of all ones or all zeros per lane, and the greater-than compare reads each byte as a signed value. An opcode byte that the block does not know is not dropped. It travels down the pipe, returns the destination unchanged and raises an illegal-operation flag. The surrounding core then decides what to do with it.

Top module: `simd_int_alu`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle with `out_valid` high two clock edges later. Back-to-back operations are accepted every cycle, and `out_valid` is never high otherwise.
- R2: Opcode byte DDh adds the four 16-bit lanes as unsigned numbers. Any lane sum above FFFFh is clamped to FFFFh.
- R3: Opcode byte FDh adds the four 16-bit lanes modulo 2^16, and no carry crosses into the next lane.
- R4: Opcode byte DBh returns dst AND src over all 64 bits. Opcode byte DFh returns (NOT dst) AND src.
- R5: Opcode bytes E0h (byte lanes) and E3h (word lanes) return the unsigned (dst + src + 1) >> 1 per lane. The sum keeps its carry, so FFh with FFh gives FFh.
- R6: Opcode bytes 74h, 75h and 76h compare byte, word and doubleword lanes respectively. An equal lane becomes all ones and an unequal lane becomes all zeros.
- R7: Opcode byte 64h sets a byte lane to FFh when the destination byte, read as two's-complement signed, is greater than the source byte. Otherwise the lane becomes 00h.
- R8: Any other opcode byte returns the destination operand unchanged, with `out_illegal` high in the same cycle as `out_valid`. `out_illegal` is low for every listed opcode and whenever `out_valid` is low.
- R9: While `rst_n` is low, `out_valid` and `out_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_opcode | input | 8 | Second opcode byte selecting the operation |
| in_dst | input | 64 | Destination operand |
| in_src | input | 64 | Source operand (register or memory) |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| out_result | output | 64 | Packed result |
| out_illegal | output | 1 | Opcode was not recognised; result is the destination |

## Verification
The directed cases target the lane edges. A saturating add of FFFFh plus 0001h must clamp to FFFFh, where a wrapping design returns 0000h. The same sum under the wrapping opcode must give 0000h and leave the next lane untouched, and a carry that leaks across lanes shows up in that neighbour. Averages of FFh with FFh and of FFFFh with FFFFh catch a sum that drops its carry before the shift, which returns 7Fh or 7FFFh. Signed byte compares of 80h against 7Fh catch an unsigned compare, which flips the mask. Random mixes of all opcodes, unknown bytes and idle gaps check the two-cycle timing and the pass-through on unknown opcodes.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    K_ADD_SAT_W,
    K_ADD_WRAP_W,
    K_AND,
    K_ANDN,
    K_AVG_B,
    K_AVG_W,
    K_EQ_B,
    K_EQ_W,
    K_EQ_D,
    K_GT_B,
    K_ILLEGAL
  } op_kind_e;

  // Map the second opcode byte onto an internal operation kind.
  function automatic op_kind_e decode_op(input logic [7:0] code);
    op_kind_e k;
    case (code)
      8'hDD:   k = K_ADD_SAT_W;
      8'hFD:   k = K_ADD_WRAP_W;
      8'hDB:   k = K_AND;
      8'hDF:   k = K_ANDN;
      8'hE0:   k = K_AVG_B;
      8'hE3:   k = K_AVG_W;
      8'h74:   k = K_EQ_B;
      8'h75:   k = K_EQ_W;
      8'h76:   k = K_EQ_D;
      8'h64:   k = K_GT_B;
      default: k = K_ILLEGAL;
    endcase
    return k;
  endfunction

  // Lane width used by a lane-wise kind; 0 for full-width bitwise kinds.
  function automatic int unsigned kind_lane_w(input op_kind_e k);
    int unsigned w;
    case (k)
      K_AVG_B, K_EQ_B, K_GT_B:                  w = 8;
      K_ADD_SAT_W, K_ADD_WRAP_W, K_AVG_W, K_EQ_W: w = 16;
      K_EQ_D:                                   w = 32;
      default:                                  w = 0;
    endcase
    return w;
  endfunction

  // Averages add a rounding one into the lane sum.
  function automatic logic kind_rounds(input op_kind_e k);
    return (k == K_AVG_B) || (k == K_AVG_W);
  endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
  import simd_alu_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind,
  output logic       illegal
);

  always_comb begin
    kind    = decode_op(opcode);
    illegal = (kind == K_ILLEGAL);
  end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_alu_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  op_kind_e            kind,
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b,
  output logic [LANE_W-1:0]   y
);

  localparam logic [LANE_W-1:0] ALL_ONES = '1;

  // Sum kept one bit wider than the lane so the carry survives.
  function automatic logic [LANE_W:0] wide_sum(
    input logic [LANE_W-1:0] x,
    input logic [LANE_W-1:0] z,
    input logic              cin
  );
    return {1'b0, x} + {1'b0, z} + {{LANE_W{1'b0}}, cin};
  endfunction

  function automatic logic [LANE_W-1:0] clamp_sum(input logic [LANE_W:0] s);
    return s[LANE_W] ? ALL_ONES : s[LANE_W-1:0];
  endfunction

  function automatic logic [LANE_W-1:0] to_mask(input logic hit);
    return hit ? ALL_ONES : '0;
  endfunction

  logic [LANE_W:0]   lane_sum;
  logic [LANE_W-1:0] wrap_v;
  logic [LANE_W-1:0] sat_v;
  logic [LANE_W-1:0] avg_v;
  logic [LANE_W-1:0] eq_v;
  logic [LANE_W-1:0] gt_v;
  logic              lane_active;

  always_comb begin
    lane_sum    = wide_sum(a, b, kind_rounds(kind));
    wrap_v      = lane_sum[LANE_W-1:0];
    sat_v       = clamp_sum(lane_sum);
    avg_v       = lane_sum[LANE_W:1];
    eq_v        = to_mask(a == b);
    gt_v        = to_mask($signed(a) > $signed(b));
    lane_active = (kind_lane_w(kind) == LANE_W);
  end

  always_comb begin
    y = '0;
    if (lane_active) begin
      case (kind)
        K_ADD_SAT_W:             y = sat_v;
        K_ADD_WRAP_W:            y = wrap_v;
        K_AVG_B, K_AVG_W:        y = avg_v;
        K_EQ_B, K_EQ_W, K_EQ_D:  y = eq_v;
        K_GT_B:                  y = gt_v;
        default:                 y = '0;
      endcase
    end
  end

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  op_kind_e            kind,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W-1:0]   y
);

  localparam int unsigned N_LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    simd_lane_unit #(.LANE_W(LANE_W)) u_lane (
      .kind (kind),
      .a    (dst[i*LANE_W +: LANE_W]),
      .b    (src[i*LANE_W +: LANE_W]),
      .y    (y[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/simd_bitwise_pass.sv
module simd_bitwise_pass
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  op_kind_e            kind,
  input  logic [DATA_W-1:0]   dst,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W-1:0]   y
);

  always_comb begin
    case (kind)
      K_AND:     y = dst & src;
      K_ANDN:    y = ~dst & src;
      K_ILLEGAL: y = dst;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned DWORD_W = 32;

  op_kind_e dec_kind;
  logic     dec_illegal;

  simd_op_decode u_dec (
    .opcode  (in_opcode),
    .kind    (dec_kind),
    .illegal (dec_illegal)
  );

  // Stage 1: decoded operation and operands.
  logic              s1_valid;
  logic              s1_illegal;
  op_kind_e          s1_kind;
  logic [DATA_W-1:0] s1_dst;
  logic [DATA_W-1:0] s1_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_illegal <= 1'b0;
      s1_kind    <= K_AND;
      s1_dst     <= '0;
      s1_src     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_illegal <= dec_illegal;
        s1_kind    <= dec_kind;
        s1_dst     <= in_dst;
        s1_src     <= in_src;
      end
    end
  end

  logic [DATA_W-1:0] byte_y;
  logic [DATA_W-1:0] word_y;
  logic [DATA_W-1:0] dword_y;
  logic [DATA_W-1:0] bit_y;
  logic [DATA_W-1:0] comb_result;

  simd_lane_group #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
    .kind (s1_kind), .dst (s1_dst), .src (s1_src), .y (byte_y)
  );

  simd_lane_group #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_words (
    .kind (s1_kind), .dst (s1_dst), .src (s1_src), .y (word_y)
  );

  simd_lane_group #(.DATA_W(DATA_W), .LANE_W(DWORD_W)) u_dwords (
    .kind (s1_kind), .dst (s1_dst), .src (s1_src), .y (dword_y)
  );

  simd_bitwise_pass #(.DATA_W(DATA_W)) u_bits (
    .kind (s1_kind), .dst (s1_dst), .src (s1_src), .y (bit_y)
  );

  // Only one group drives non-zero for any kind, so an OR merges them.
  assign comb_result = byte_y | word_y | dword_y | bit_y;

  // Stage 2: registered result.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= s1_valid;
      out_illegal <= s1_valid & s1_illegal;
      if (s1_valid) begin
        out_result <= comb_result;
      end
    end
  end

endmodule

// File: rtl/simd_int_alu_chk.sv
module simd_int_alu_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        in_opcode,
  input logic [DATA_W-1:0] in_dst,
  input logic [DATA_W-1:0] in_src,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_opcode, 2) == 8'hDB)
      |-> out_result == ($past(in_dst, 2) & $past(in_src, 2)));

  p_dword_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_opcode, 2) == 8'h76)
      |-> (out_result[31:0] == 32'h0 || out_result[31:0] == 32'hFFFF_FFFF));

  p_illegal_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && out_result == $past(in_dst, 2)));

  p_illegal_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_illegal);

endmodule

bind simd_int_alu simd_int_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_opcode   (in_opcode),
  .in_dst      (in_dst),
  .in_src      (in_src),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/simd_int_alu_test.sv
module simd_int_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_opcode = 8'h00;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_int_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  // Reference model, written lane by lane with integer arithmetic.
  function automatic logic [64:0] model(input logic [7:0] op,
                                        input logic [63:0] d,
                                        input logic [63:0] s);
    logic [63:0] r = '0;
    logic ill = 1'b0;
    int x, z;
    case (op)
      8'hDD, 8'hFD, 8'hE3, 8'h75:
        for (int i = 0; i < 4; i++) begin
          x = int'(d[16*i +: 16]); z = int'(s[16*i +: 16]);
          case (op)
            8'hDD: r[16*i +: 16] = 16'((x + z > 65535) ? 65535 : x + z);
            8'hFD: r[16*i +: 16] = 16'((x + z) % 65536);
            8'hE3: r[16*i +: 16] = 16'((x + z + 1) / 2);
            default: r[16*i +: 16] = (x == z) ? 16'hFFFF : 16'h0000;
          endcase
        end
      8'hE0, 8'h74, 8'h64:
        for (int i = 0; i < 8; i++) begin
          x = int'(d[8*i +: 8]); z = int'(s[8*i +: 8]);
          case (op)
            8'hE0: r[8*i +: 8] = 8'((x + z + 1) / 2);
            8'h74: r[8*i +: 8] = (x == z) ? 8'hFF : 8'h00;
            default: begin
              if (x > 127) x = x - 256;
              if (z > 127) z = z - 256;
              r[8*i +: 8] = (x > z) ? 8'hFF : 8'h00;
            end
          endcase
        end
      8'h76:
        for (int i = 0; i < 2; i++)
          r[32*i +: 32] = (d[32*i +: 32] == s[32*i +: 32]) ? 32'hFFFF_FFFF : 32'h0;
      8'hDB: r = d & s;
      8'hDF: r = ~d & s;
      default: begin r = d; ill = 1'b1; end
    endcase
    return {ill, r};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'hDD: return "R2";
      8'hFD: return "R3";
      8'hDB, 8'hDF: return "R4";
      8'hE0, 8'hE3: return "R5";
      8'h74, 8'h75, 8'h76: return "R6";
      8'h64: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Pipeline of issued operations, one entry per negedge.
  logic        p1_v = 0, p2_v = 0;
  logic [7:0]  p1_op, p2_op;
  logic [63:0] p1_d, p2_d, p1_s, p2_s;

  task automatic check_out();
    logic [64:0] e;
    checks++;
    if (!p2_v) begin
      if (out_valid !== 1'b0 || out_illegal !== 1'b0) begin
        errors++;
        $display("FAIL R1 idle: valid=%b illegal=%b expected 0 0", out_valid, out_illegal);
      end
    end else begin
      e = model(p2_op, p2_d, p2_s);
      if (out_valid !== 1'b1 || out_result !== e[63:0] || out_illegal !== e[64]) begin
        errors++;
        $display("FAIL %s op=%h d=%h s=%h: valid=%b res=%h ill=%b expected 1 %h %b",
                 tag_of(p2_op), p2_op, p2_d, p2_s, out_valid, out_result,
                 out_illegal, e[63:0], e[64]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [7:0] op,
                      input logic [63:0] d, input logic [63:0] s);
    @(negedge clk);
    check_out();
    p2_v = p1_v; p2_op = p1_op; p2_d = p1_d; p2_s = p1_s;
    p1_v = v;    p1_op = op;    p1_d = d;    p1_s = s;
    in_valid = v; in_opcode = op; in_dst = d; in_src = s;
  endtask

  localparam logic [7:0] OPS [10] = '{8'hDD, 8'hFD, 8'hDB, 8'hDF, 8'hE0,
                                      8'hE3, 8'h74, 8'h75, 8'h76, 8'h64};

  initial begin
    void'($urandom(32'd1234));
    // R9: outputs quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_illegal !== 1'b0) begin
        errors++;
        $display("FAIL R9 reset: valid=%b illegal=%b expected 0 0", out_valid, out_illegal);
      end
    end
    rst_n = 1'b1;
    // Directed corners
    step(1, 8'hDD, 64'h8000_0001_FFFF_1234, 64'h8000_FFFF_0001_0001); // R2 clamp
    step(1, 8'hFD, 64'h0001_8000_FFFF_1234, 64'h0000_8000_0001_0001); // R3 wrap
    step(1, 8'hDB, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_AAAA_FFFF); // R4
    step(1, 8'hDF, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_AAAA_FFFF); // R4
    step(1, 8'hE0, 64'hFF00_01FE_0080_FF7F, 64'hFF01_00FF_0081_0080); // R5
    step(1, 8'hE3, 64'hFFFF_0000_0001_8000, 64'hFFFF_0001_0000_8001); // R5
    step(1, 8'h74, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788); // R6
    step(1, 8'h75, 64'h1122_3344_5566_7788, 64'h1122_3345_5566_0000); // R6
    step(1, 8'h76, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0000); // R6
    step(1, 8'h64, 64'h807F_0000_FF01_7F80, 64'h7F80_0000_0000_807F); // R7 signed
    step(1, 8'h00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF); // R8
    step(0, 8'hDD, 64'h0, 64'h0);                                     // R1 gap
    step(1, 8'hFF, 64'hCAFE_F00D_1234_5678, 64'h0);                   // R8
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] op;
      logic [63:0] d, s;
      op = ($urandom % 8 == 0) ? 8'($urandom) : OPS[$urandom % 10];
      d = {$urandom, $urandom};
      s = ($urandom % 4 == 0) ? d ^ (64'h1 << ($urandom % 64)) : {$urandom, $urandom};
      if ($urandom % 5 == 0) s = d;
      step(($urandom % 4) != 0, op, d, s);
    end
    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule